// File: doc/BRIEF.md
# I2S Master Audio Transceiver

The block is a bus-master stereo serial audio port for 16-bit samples. The host pushes samples into a transmit queue and pops received samples from a receive queue. Two status flags tell the host when each queue needs service, so the host can keep the queues filled and drained while the serial link runs. The host sees both queues as 32 words of 16 bits, which is 64 bytes each.

The system clock feeds two 5-bit dividers. The first gives the interface master clock, which sets the serial bit rate. The second drives the free-running codec clock output. Each master-clock pulse moves a small state machine through its states. The machine produces the bit clock and the word-select line, and it loads or unloads one 16-bit shift register per channel slot. Every slot has sixteen bit-clock periods, with the left channel first. Data goes out MSB first, one bit-clock period after each word-select change. Incoming data is sampled on the rising bit-clock edge.

Engine states and transitions:
- `ENG_IDLE`: the bit clock is held low. On the first master tick while `run` is high, the machine goes to `ENG_SCLK_LO`.
- `ENG_SCLK_LO` to `ENG_SCLK_HI` is the rising edge. The receive shifter samples here, and a finished word is pushed.
- `ENG_SCLK_HI` to `ENG_SCLK_LO` is the falling edge. The slot bit counter advances here, the word-select line toggles, and the transmit word is loaded.
- Any state goes to `ENG_IDLE` in the same cycle that `run` is low.

Top module: `i2s_master_xcvr`

## Requirements
- R1: The master divider emits one pulse every `mclk_div`+1 system cycles. Each bit-clock phase (high or low) therefore lasts exactly `mclk_div`+1 cycles, and `mclk_div`=0 gives one cycle per phase.
- R2: `cdclk` toggles once every `cdclk_div`+1 system cycles, whether `run` is high or low.
- R3: `sclk` is low in reset and while idle. While running, it changes only one cycle after a master pulse.
- R4: `lrck` is low after start, which selects the left slot. It toggles only at falling `sclk` edges, once every 16 `sclk` periods.
- R5: On the first falling `sclk` edge after each `lrck` change, a queued word is loaded. `sd_out` then carries bits 15 down to 1 in the next 15 periods and bit 0 in the period after the next `lrck` change.
- R6: If the transmit queue is empty at a load, the slot sends sixteen zeros.
- R7: `sd_in` is sampled on each rising `sclk` edge. A word holds the 16 samples from the second period of a slot through the first period of the next slot, MSB first. It is queued at the rising edge of that first period. The word of the very first slot after start is not queued.
- R8: `tx_ready` is 1 exactly when the transmit queue is not empty. `tx_full` is 1 when the queue holds 32 words.
- R9: `rx_ready` is 1 exactly when the receive queue holds fewer than 32 words. `rx_avail` is 1 when it holds at least one word. `rx_data` shows the oldest word, and `rx_rd` pops it.
- R10: A word that arrives while the receive queue is full is dropped and sets `rx_overrun`. The flag stays set until `overrun_clr` is high in a cycle with no new overrun.
- R11: Both queues are first-in first-out and hold 32 words. A host write while the transmit queue is full is ignored. The full test uses the occupancy at the start of the cycle.
- R12: With `run` low, `sclk`, `lrck` and `sd_out` return to 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables the serial engine |
| mclk_div | input | 5 | Master divider setting N, divide by N+1 |
| cdclk_div | input | 5 | Codec divider setting N, toggle every N+1 |
| tx_wr | input | 1 | Push `tx_data` into the transmit queue |
| tx_data | input | 16 | Transmit sample |
| tx_ready | output | 1 | Transmit queue not empty |
| tx_full | output | 1 | Transmit queue full |
| rx_rd | input | 1 | Pop the oldest received sample |
| rx_data | output | 16 | Oldest received sample |
| rx_avail | output | 1 | Receive queue not empty |
| rx_ready | output | 1 | Receive queue not full |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| overrun_clr | input | 1 | Clears `rx_overrun` |
| sclk | output | 1 | Serial bit clock |
| lrck | output | 1 | Word select, low for left |
| sd_out | output | 1 | Serial data out |
| sd_in | input | 1 | Serial data in |
| cdclk | output | 1 | Codec clock output |

## Verification
The assertions assume three things about the inputs:
- The divider settings change only while the engine is stopped, or not at all.
- `run` is a level that stays high across whole slots.
- `sd_in` changes only away from the rising system-clock edge.

The stimulus meets all three. It sets the dividers and writes queue data with `run` low. It drives every input on the falling system-clock edge. In loopback it returns `sd_out` to `sd_in` through a register clocked on the falling edge, so each received bit is the one sent in the same bit period.

// File: rtl/i2s_pkg.sv
package i2s_pkg;

    localparam int SAMPLE_W = 16;

    typedef enum logic [1:0] {
        ENG_IDLE    = 2'd0,
        ENG_SCLK_LO = 2'd1,
        ENG_SCLK_HI = 2'd2
    } eng_state_t;

endpackage

// File: rtl/i2s_prescaler.sv
module i2s_prescaler #(
    parameter int DW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] div,
    output logic          tick
);

    logic [DW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q >= div) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end

    // R1: with a nonzero divisor two pulses are never adjacent
    a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> !tick);

endmodule

// File: rtl/i2s_fifo.sv
module i2s_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);

    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;
    logic          push_ok, pop_ok;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == (AW+1)'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rp_q];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp_q] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wp_q <= wp_q + 1'b1;
            if (pop_ok)  rp_q <= rp_q + 1'b1;
            cnt_q <= cnt_q + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
        end
    end

    // R11: a full queue stays full while only writes arrive
    a_r11_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);

    // R8: an empty queue stays empty without a write
    a_r8_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push) |=> empty);

endmodule

// File: rtl/i2s_chan_engine.sv
module i2s_chan_engine
    import i2s_pkg::*;
#(
    parameter int W         = SAMPLE_W,
    parameter int SLOT_BITS = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         bit_tick,
    input  logic         sd_in,
    input  logic         tx_empty,
    input  logic [W-1:0] tx_head,
    output logic         tx_pop,
    output logic         rx_push,
    output logic [W-1:0] rx_word,
    output logic         sclk,
    output logic         lrck,
    output logic         sd_out
);

    localparam int CW = $clog2(SLOT_BITS);

    eng_state_t    st_q, st_d;
    logic [CW-1:0] bit_q, bit_d, bit_nx;
    logic          lr_q, lr_d;
    logic          primed_q, primed_d;
    logic [W-1:0]  tx_sh_q, tx_sh_d;
    logic [W-1:0]  rx_sh_q, rx_sh_d;

    assign bit_nx = (bit_q == CW'(SLOT_BITS-1)) ? '0 : bit_q + 1'b1;

    // state and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ENG_IDLE;
            bit_q    <= '0;
            lr_q     <= 1'b0;
            primed_q <= 1'b0;
            tx_sh_q  <= '0;
            rx_sh_q  <= '0;
        end else begin
            st_q     <= st_d;
            bit_q    <= bit_d;
            lr_q     <= lr_d;
            primed_q <= primed_d;
            tx_sh_q  <= tx_sh_d;
            rx_sh_q  <= rx_sh_d;
        end
    end

    // transitions and per-edge actions
    always_comb begin
        st_d     = st_q;
        bit_d    = bit_q;
        lr_d     = lr_q;
        primed_d = primed_q;
        tx_sh_d  = tx_sh_q;
        rx_sh_d  = rx_sh_q;
        tx_pop   = 1'b0;
        rx_push  = 1'b0;
        rx_word  = {rx_sh_q[W-2:0], sd_in};
        if (!run) begin
            st_d     = ENG_IDLE;
            bit_d    = '0;
            lr_d     = 1'b0;
            primed_d = 1'b0;
            tx_sh_d  = '0;
        end else if (bit_tick) begin
            unique case (st_q)
                ENG_IDLE: begin
                    st_d  = ENG_SCLK_LO;
                    bit_d = '0;
                    lr_d  = 1'b0;
                end
                ENG_SCLK_LO: begin
                    st_d    = ENG_SCLK_HI;
                    rx_sh_d = rx_word;
                    if (bit_q == '0 && primed_q) rx_push = 1'b1;
                    if (bit_q == CW'(1))         primed_d = 1'b1;
                end
                ENG_SCLK_HI: begin
                    st_d  = ENG_SCLK_LO;
                    bit_d = bit_nx;
                    if (bit_nx == '0) lr_d = ~lr_q;
                    if (bit_nx == CW'(1)) begin
                        tx_pop  = !tx_empty;
                        tx_sh_d = tx_empty ? '0 : tx_head;
                    end else begin
                        tx_sh_d = {tx_sh_q[W-2:0], 1'b0};
                    end
                end
                default: st_d = ENG_IDLE;
            endcase
        end
    end

    // pin outputs
    always_comb begin
        sclk   = (st_q == ENG_SCLK_HI);
        lrck   = lr_q;
        sd_out = tx_sh_q[W-1];
    end

    // R3: bit clock moves only after a master pulse while running
    a_r3_sclk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && !$stable(sclk)) |-> $past(bit_tick));

    // R4: word select changes only with a falling bit clock while running
    a_r4_lrck_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && !$stable(lrck)) |-> $fell(sclk));

    // R12: stopping drops the bit clock on the next edge
    a_r12_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sclk);

endmodule

// File: rtl/i2s_master_xcvr.sv
module i2s_master_xcvr
    import i2s_pkg::*;
#(
    parameter int DIV_W      = 5,
    parameter int FIFO_BYTES = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [DIV_W-1:0]    mclk_div,
    input  logic [DIV_W-1:0]    cdclk_div,
    input  logic                tx_wr,
    input  logic [SAMPLE_W-1:0] tx_data,
    output logic                tx_ready,
    output logic                tx_full,
    input  logic                rx_rd,
    output logic [SAMPLE_W-1:0] rx_data,
    output logic                rx_avail,
    output logic                rx_ready,
    output logic                rx_overrun,
    input  logic                overrun_clr,
    output logic                sclk,
    output logic                lrck,
    output logic                sd_out,
    input  logic                sd_in,
    output logic                cdclk
);

    localparam int DEPTH  = FIFO_BYTES / (SAMPLE_W / 8);
    localparam int N_DIVS = 2;

    logic [N_DIVS-1:0][DIV_W-1:0] div_set;
    logic [N_DIVS-1:0]            ticks;
    logic                         tx_empty, tx_pop;
    logic [SAMPLE_W-1:0]          tx_head;
    logic                         rx_empty, rx_full, rx_push;
    logic [SAMPLE_W-1:0]          rx_word;
    logic                         ovr_q, cd_q;

    assign div_set[0] = mclk_div;
    assign div_set[1] = cdclk_div;

    for (genvar g = 0; g < N_DIVS; g++) begin : g_div
        i2s_prescaler #(.DW(DIV_W)) u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .div   (div_set[g]),
            .tick  (ticks[g])
        );
    end

    i2s_fifo #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_tx_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tx_wr),
        .push_data (tx_data),
        .pop       (tx_pop),
        .head      (tx_head),
        .empty     (tx_empty),
        .full      (tx_full)
    );

    i2s_fifo #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_rx_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_push),
        .push_data (rx_word),
        .pop       (rx_rd),
        .head      (rx_data),
        .empty     (rx_empty),
        .full      (rx_full)
    );

    i2s_chan_engine #(.W(SAMPLE_W), .SLOT_BITS(16)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .bit_tick (ticks[0]),
        .sd_in    (sd_in),
        .tx_empty (tx_empty),
        .tx_head  (tx_head),
        .tx_pop   (tx_pop),
        .rx_push  (rx_push),
        .rx_word  (rx_word),
        .sclk     (sclk),
        .lrck     (lrck),
        .sd_out   (sd_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
            cd_q  <= 1'b0;
        end else begin
            if (rx_push && rx_full) ovr_q <= 1'b1;
            else if (overrun_clr)   ovr_q <= 1'b0;
            if (ticks[1]) cd_q <= ~cd_q;
        end
    end

    assign tx_ready   = !tx_empty;
    assign rx_avail   = !rx_empty;
    assign rx_ready   = !rx_full;
    assign rx_overrun = ovr_q;
    assign cdclk      = cd_q;

    // R10: overrun flag is sticky until cleared
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !overrun_clr) |=> rx_overrun);

    // R10: a word arriving at a full queue raises the flag
    a_r10_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full) |=> rx_overrun);

endmodule

// File: tb/i2s_master_xcvr_tb.sv
module i2s_master_xcvr_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [4:0]  mclk_div = 5'd1;
    logic [4:0]  cdclk_div = 5'd2;
    logic        tx_wr = 1'b0;
    logic [15:0] tx_data = 16'h0;
    logic        rx_rd = 1'b0;
    logic        overrun_clr = 1'b0;
    logic        sd_in = 1'b0;
    logic        loop = 1'b0;
    logic        tx_ready, tx_full, rx_avail, rx_ready, rx_overrun;
    logic        sclk, lrck, sd_out, cdclk;
    logic [15:0] rx_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2s_master_xcvr u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .mclk_div(mclk_div), .cdclk_div(cdclk_div),
        .tx_wr(tx_wr), .tx_data(tx_data), .tx_ready(tx_ready), .tx_full(tx_full),
        .rx_rd(rx_rd), .rx_data(rx_data), .rx_avail(rx_avail), .rx_ready(rx_ready),
        .rx_overrun(rx_overrun), .overrun_clr(overrun_clr), .sclk(sclk), .lrck(lrck),
        .sd_out(sd_out), .sd_in(sd_in), .cdclk(cdclk)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // serial input: loopback or random, changed away from the rising edge
    always @(negedge clk) sd_in <= loop ? sd_out : 1'($urandom);

    // behavioural reference model
    int          m_mcnt, m_ccnt, m_st, m_bcnt;
    bit          m_mtick, m_ctick, m_cd, m_lr, m_primed, m_ovr;
    logic [15:0] m_txsh, m_rxsh;
    logic [15:0] txq[$];
    logic [15:0] rxq[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mcnt = 0; m_ccnt = 0; m_mtick = 0; m_ctick = 0; m_cd = 0;
            m_st = 0; m_bcnt = 0; m_lr = 0; m_primed = 0; m_ovr = 0;
            m_txsh = 0; m_rxsh = 0;
            txq.delete(); rxq.delete();
        end else begin
            bit o_mtick, o_ctick, tx_e, tx_f, rx_e, rx_f, pop_t, push_r;
            int o_st;
            logic [15:0] word;
            o_mtick = m_mtick; o_ctick = m_ctick; o_st = m_st;
            tx_e = (txq.size() == 0); tx_f = (txq.size() == 32);
            rx_e = (rxq.size() == 0); rx_f = (rxq.size() == 32);
            pop_t = 0; push_r = 0; word = 0;
            if (m_mcnt >= int'(mclk_div)) begin m_mcnt = 0; m_mtick = 1; end
            else begin m_mcnt++; m_mtick = 0; end
            if (m_ccnt >= int'(cdclk_div)) begin m_ccnt = 0; m_ctick = 1; end
            else begin m_ccnt++; m_ctick = 0; end
            if (o_ctick) m_cd = !m_cd;
            if (!run) begin
                m_st = 0; m_bcnt = 0; m_lr = 0; m_primed = 0; m_txsh = 0;
            end else if (o_mtick) begin
                if (o_st == 0) begin
                    m_st = 1; m_bcnt = 0; m_lr = 0;
                end else if (o_st == 1) begin
                    m_st = 2;
                    word = {m_rxsh[14:0], sd_in};
                    if (m_bcnt == 0 && m_primed) push_r = 1;
                    if (m_bcnt == 1) m_primed = 1;
                    m_rxsh = word;
                end else begin
                    m_st = 1;
                    m_bcnt = (m_bcnt + 1) % 16;
                    if (m_bcnt == 0) m_lr = !m_lr;
                    if (m_bcnt == 1) begin
                        if (!tx_e) begin m_txsh = txq[0]; pop_t = 1; end
                        else m_txsh = 16'h0;
                    end else m_txsh = m_txsh << 1;
                end
            end
            if (pop_t) void'(txq.pop_front());
            if (tx_wr && !tx_f) txq.push_back(tx_data);
            if (rx_rd && !rx_e) void'(rxq.pop_front());
            if (push_r && !rx_f) rxq.push_back(word);
            if (push_r && rx_f) m_ovr = 1;
            else if (overrun_clr) m_ovr = 0;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3", "sclk", 32'(sclk), 32'(m_st == 2));
            chk("R4", "lrck", 32'(lrck), 32'(m_lr));
            chk("R5", "sd_out", 32'(sd_out), 32'(m_txsh[15]));
            chk("R2", "cdclk", 32'(cdclk), 32'(m_cd));
            chk("R8", "tx_ready", 32'(tx_ready), 32'(txq.size() != 0));
            chk("R8", "tx_full", 32'(tx_full), 32'(txq.size() == 32));
            chk("R9", "rx_ready", 32'(rx_ready), 32'(rxq.size() != 32));
            chk("R9", "rx_avail", 32'(rx_avail), 32'(rxq.size() != 0));
            if (rxq.size() != 0) chk("R7", "rx_data", 32'(rx_data), 32'(rxq[0]));
            chk("R10", "rx_overrun", 32'(rx_overrun), 32'(m_ovr));
        end
    end

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic read_word(output logic [15:0] w);
        while (!rx_avail) @(negedge clk);
        w = rx_data;
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic write_word(input logic [15:0] w);
        tx_wr = 1'b1;
        tx_data = w;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    initial begin
        logic [15:0] pat [8];
        logic [15:0] got;
        int n;
        pat[0] = 16'hA5C3; pat[1] = 16'h8001; pat[2] = 16'h7FFE; pat[3] = 16'h1234;
        pat[4] = 16'hFFFF; pat[5] = 16'h0001; pat[6] = 16'h8000; pat[7] = 16'h5AA5;

        repeat (3) @(negedge clk);
        // reset values (R3 R4 R8 R9 R10)
        chk("R3", "reset sclk", 32'(sclk), 0);
        chk("R4", "reset lrck", 32'(lrck), 0);
        chk("R8", "reset tx_ready", 32'(tx_ready), 0);
        chk("R9", "reset rx_ready", 32'(rx_ready), 1);
        chk("R10", "reset overrun", 32'(rx_overrun), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // loopback with preloaded words
        foreach (pat[i]) write_word(pat[i]);
        chk("R8", "tx_ready after writes", 32'(tx_ready), 1);
        loop = 1'b1;
        run = 1'b1;
        // R1: bit-clock phase length
        while (sclk) @(negedge clk);
        while (!sclk) @(negedge clk);
        n = 0;
        while (sclk) begin n++; @(negedge clk); end
        chk("R1", "sclk high phase cycles", 32'(n), 32'(mclk_div) + 1);
        // R2: codec clock half period
        begin
            bit c0;
            c0 = cdclk;
            while (cdclk == c0) @(negedge clk);
            c0 = cdclk; n = 0;
            while (cdclk == c0) begin n++; @(negedge clk); end
            chk("R2", "cdclk half period cycles", 32'(n), 32'(cdclk_div) + 1);
        end
        for (int i = 0; i < 8; i++) begin
            read_word(got);
            chk("R5", "loopback word", 32'(got), 32'(pat[i]));
        end
        for (int i = 0; i < 2; i++) begin
            read_word(got);
            chk("R6", "underflow slot word", 32'(got), 0);
        end
        run = 1'b0;
        @(negedge clk);
        chk("R12", "sclk after stop", 32'(sclk), 0);
        chk("R12", "lrck after stop", 32'(lrck), 0);
        chk("R12", "sd_out after stop", 32'(sd_out), 0);
        while (rx_avail) read_word(got);

        // overrun with random input, fastest rate
        mclk_div = 5'd0;
        cdclk_div = 5'd0;
        loop = 1'b0;
        @(negedge clk);
        run = 1'b1;
        n = 0;
        while (!rx_overrun && n < 4000) begin n++; @(negedge clk); end
        chk("R10", "overrun raised", 32'(rx_overrun), 1);
        chk("R9", "rx_ready when full", 32'(rx_ready), 0);
        run = 1'b0;
        repeat (5) @(negedge clk);
        chk("R10", "overrun sticky", 32'(rx_overrun), 1);
        overrun_clr = 1'b1;
        @(negedge clk);
        overrun_clr = 1'b0;
        chk("R10", "overrun cleared", 32'(rx_overrun), 0);
        n = 0;
        while (rx_avail) begin read_word(got); n++; end
        chk("R11", "receive depth", 32'(n), 32);

        // transmit queue full, extra write ignored
        for (int i = 0; i < 33; i++) write_word(16'(i * 16'h0107 + 16'h0011));
        chk("R11", "tx_full", 32'(tx_full), 1);
        loop = 1'b1;
        run = 1'b1;
        for (int i = 0; i < 32; i++) begin
            read_word(got);
            chk("R11", "fifo order", 32'(got), 32'(16'(i * 16'h0107 + 16'h0011)));
        end
        read_word(got);
        chk("R11", "write while full dropped", 32'(got), 0);
        run = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule